// File: doc/BRIEF.md
# Sample-Rate Speed-Mode Detector

This block sorts the rate of an incoming audio frame-sync signal into one of three speed bands and reports the oversampling ratio that goes with each band. It counts reference-clock cycles from one rising edge of the frame sync to the next and compares that period against thresholds for 50 kHz, 100 kHz and 200 kHz. Periods shorter than the 200 kHz period are flagged as out of range. A new band is adopted only after two measurements in a row agree, so a rate sitting near a band edge does not make the result flicker.

An automatic-enable input chooses between the measured band and a band forced from configuration inputs. A filter-select output passes the software choice between slow and fast roll-off, except in pin-strapped configuration, where it is held at fast roll-off. The frame sync is taken as already synchronous to the reference clock.

Top module: `speed_mode_detect`

## Requirements
- R1: After reset, mode is 2'b00 (single), osr is 128, rate_valid is 0 and out_of_range is 0.
- R2: The period is the number of reference-clock cycles between two successive rising edges of frame_sync. A period of at least floor(REF_KHZ/50) is single (2'b00), at least floor(REF_KHZ/100) is double (2'b01), at least floor(REF_KHZ/200) is quad (2'b10). The first rising edge after reset only starts a measurement.
- R3: osr is 128 when mode is 2'b00, 64 when mode is 2'b01, and 32 when mode is 2'b10.
- R4: With auto_en high, the mode changes only when two consecutive measurements give the same in-range band. A single measurement that differs leaves the mode unchanged.
- R5: rate_valid rises when the first agreeing pair of in-range measurements is seen. It falls on an out-of-range measurement. rate_valid and out_of_range are never high together.
- R6: A period below floor(REF_KHZ/200) sets out_of_range in the cycle after the measurement completes, and the detected mode keeps its previous value. The next in-range measurement clears out_of_range.
- R7: With auto_en low, mode follows force_mode, with 2'b11 taken as quad (2'b10), and osr follows mode.
- R8: With hw_strap high, filt_slow is 0 whatever filt_sel_sw is. With hw_strap low, filt_slow equals filt_sel_sw.
- R9: A period exactly on a threshold belongs to the slower band. With REF_KHZ=12288, periods of 245, 244, 121, 61 and 60 give single, double, quad, quad and out of range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | Frame-rate sync, synchronous to clk |
| auto_en | input | 1 | 1: use the measured band, 0: use force_mode |
| force_mode | input | 2 | Forced band code |
| hw_strap | input | 1 | Pin-strapped configuration, restricts the filter choice |
| filt_sel_sw | input | 1 | Software filter choice, 1 = slow roll-off |
| mode | output | 2 | Band code: 00 single, 01 double, 10 quad |
| osr | output | 8 | Oversampling ratio for mode |
| rate_valid | output | 1 | Measured rate is settled and in range |
| out_of_range | output | 1 | Last measured rate is above the quad band |
| filt_slow | output | 1 | Selected roll-off, 1 = slow |

## Verification
A corrupted period count or a misplaced threshold gives the wrong band code and ratio at the ports two frames after the rate changes. The directed boundary periods expose an off-by-one error at once. A broken agreement register shows up either as a mode that follows a single odd frame, which the hold scenario catches in the following frame, or as a mode that never settles, which shows as rate_valid staying low. A stuck out-of-range state shows as rate_valid and out_of_range both wrong one cycle after the first fast frame.

// File: rtl/smd_pkg.sv
package smd_pkg;
  typedef enum logic [1:0] {
    CLS_SINGLE = 2'b00,
    CLS_DOUBLE = 2'b01,
    CLS_QUAD   = 2'b10,
    CLS_OOR    = 2'b11
  } rate_cls_e;
endpackage

// File: rtl/smd_period_counter.sv
module smd_period_counter #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_sync,
  output logic [CNT_W-1:0] period,
  output logic             meas_stb
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             fs_q, armed_q, stb_q;
  logic [CNT_W-1:0] cnt_q, per_q;
  logic             armed_d, stb_d, rise;
  logic [CNT_W-1:0] cnt_d, per_d;

  always_comb begin
    rise    = frame_sync & ~fs_q;
    cnt_d   = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_ONE;
    per_d   = per_q;
    stb_d   = 1'b0;
    armed_d = armed_q;
    if (rise) begin
      cnt_d   = CNT_ONE;
      per_d   = cnt_q;
      stb_d   = armed_q;
      armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q    <= 1'b0;
      cnt_q   <= '0;
      per_q   <= '0;
      stb_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      fs_q    <= frame_sync;
      cnt_q   <= cnt_d;
      per_q   <= per_d;
      stb_q   <= stb_d;
      armed_q <= armed_d;
    end
  end

  assign period   = per_q;
  assign meas_stb = stb_q;
endmodule

// File: rtl/smd_classify.sv
module smd_classify
  import smd_pkg::*;
#(
  parameter int CNT_W = 9,
  parameter int TH_SS = 245,
  parameter int TH_DS = 122,
  parameter int TH_QS = 61
) (
  input  logic [CNT_W-1:0] period,
  output rate_cls_e        cls
);
  localparam logic [CNT_W-1:0] LIM_SS = CNT_W'(TH_SS);
  localparam logic [CNT_W-1:0] LIM_DS = CNT_W'(TH_DS);
  localparam logic [CNT_W-1:0] LIM_QS = CNT_W'(TH_QS);

  always_comb begin
    if (period >= LIM_SS)      cls = CLS_SINGLE;
    else if (period >= LIM_DS) cls = CLS_DOUBLE;
    else if (period >= LIM_QS) cls = CLS_QUAD;
    else                       cls = CLS_OOR;
  end
endmodule

// File: rtl/smd_debounce.sv
module smd_debounce
  import smd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       meas_stb,
  input  rate_cls_e  cls,
  output logic [1:0] det_mode,
  output logic       rate_valid,
  output logic       out_of_range
);
  rate_cls_e  prev_q, prev_d;
  logic [1:0] mode_q, mode_d;
  logic       valid_q, valid_d, oor_q, oor_d;

  always_comb begin
    prev_d  = prev_q;
    mode_d  = mode_q;
    valid_d = valid_q;
    oor_d   = oor_q;
    if (meas_stb) begin
      prev_d = cls;
      if (cls == CLS_OOR) begin
        oor_d   = 1'b1;
        valid_d = 1'b0;
      end else begin
        oor_d = 1'b0;
        if (cls == prev_q) begin
          mode_d  = cls;
          valid_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= CLS_OOR;
      mode_q  <= CLS_SINGLE;
      valid_q <= 1'b0;
      oor_q   <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      mode_q  <= mode_d;
      valid_q <= valid_d;
      oor_q   <= oor_d;
    end
  end

  assign det_mode     = mode_q;
  assign rate_valid   = valid_q;
  assign out_of_range = oor_q;
endmodule

// File: rtl/speed_mode_detect.sv
module speed_mode_detect
  import smd_pkg::*;
#(
  parameter int REF_KHZ = 12288
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_sync,
  input  logic       auto_en,
  input  logic [1:0] force_mode,
  input  logic       hw_strap,
  input  logic       filt_sel_sw,
  output logic [1:0] mode,
  output logic [7:0] osr,
  output logic       rate_valid,
  output logic       out_of_range,
  output logic       filt_slow
);
  localparam int TH_SS = REF_KHZ / 50;
  localparam int TH_DS = REF_KHZ / 100;
  localparam int TH_QS = REF_KHZ / 200;
  localparam int CNT_W = $clog2(TH_SS + 1) + 1;

  logic             rst_s1, rst_s2;
  logic [CNT_W-1:0] period;
  logic             meas_stb;
  rate_cls_e        cls;
  logic [1:0]       det_mode;

  // reset asserts at once and is released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  smd_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_s2), .frame_sync(frame_sync),
    .period(period), .meas_stb(meas_stb)
  );

  smd_classify #(.CNT_W(CNT_W), .TH_SS(TH_SS), .TH_DS(TH_DS), .TH_QS(TH_QS)) u_cls (
    .period(period), .cls(cls)
  );

  smd_debounce u_deb (
    .clk(clk), .rst_n(rst_s2), .meas_stb(meas_stb), .cls(cls),
    .det_mode(det_mode), .rate_valid(rate_valid), .out_of_range(out_of_range)
  );

  always_comb begin
    if (auto_en)                   mode = det_mode;
    else if (force_mode == 2'b11)  mode = 2'b10;
    else                           mode = force_mode;
    case (mode)
      2'b00:   osr = 8'd128;
      2'b01:   osr = 8'd64;
      default: osr = 8'd32;
    endcase
    filt_slow = filt_sel_sw & ~hw_strap;
  end
endmodule

// File: rtl/smd_chk.sv
module smd_chk #(
  parameter int CNT_W = 9,
  parameter int TH_QS = 61
) (
  input logic             clk,
  input logic             rst_n,
  input logic             auto_en,
  input logic             hw_strap,
  input logic             stb,
  input logic [CNT_W-1:0] period,
  input logic [1:0]       mode,
  input logic [7:0]       osr,
  input logic             rate_valid,
  input logic             out_of_range,
  input logic             filt_slow
);
  // R3
  osr_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(osr) == 1 && (osr[7] || osr[6] || osr[5]));
  // R4
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && $past(auto_en) && !$past(stb)) |-> $stable(mode));
  // R5
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rate_valid) |-> $past(stb));
  // R5
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rate_valid && out_of_range));
  // R6
  oor_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && period < CNT_W'(TH_QS)) |=> out_of_range);
  // R8
  hw_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_strap |-> !filt_slow);
endmodule

bind speed_mode_detect smd_chk #(.CNT_W(CNT_W), .TH_QS(TH_QS)) u_chk (
  .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .hw_strap(hw_strap),
  .stb(meas_stb), .period(period), .mode(mode), .osr(osr),
  .rate_valid(rate_valid), .out_of_range(out_of_range), .filt_slow(filt_slow)
);

// File: tb/speed_mode_detect_test.sv
module speed_mode_detect_test;
  localparam int CLK_PERIOD = 10;
  localparam int REF_KHZ = 12288;
  localparam int T_SS = REF_KHZ / 50;
  localparam int T_DS = REF_KHZ / 100;
  localparam int T_QS = REF_KHZ / 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_sync = 1'b0;
  logic auto_en = 1'b1;
  logic [1:0] force_mode = 2'b00;
  logic hw_strap = 1'b0;
  logic filt_sel_sw = 1'b0;
  logic [1:0] mode;
  logic [7:0] osr;
  logic rate_valid, out_of_range, filt_slow;

  int n_checks = 0;
  int n_fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  speed_mode_detect #(.REF_KHZ(REF_KHZ)) uut (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .auto_en(auto_en),
    .force_mode(force_mode), .hw_strap(hw_strap), .filt_sel_sw(filt_sel_sw),
    .mode(mode), .osr(osr), .rate_valid(rate_valid),
    .out_of_range(out_of_range), .filt_slow(filt_slow)
  );

  function automatic logic [7:0] exp_osr(input logic [1:0] m);
    return (m == 2'b00) ? 8'd128 : (m == 2'b01) ? 8'd64 : 8'd32;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_frames(input int p, input int n);
    for (int i = 0; i < n; i++) begin
      frame_sync = 1'b1;
      repeat (p / 2) @(negedge clk);
      frame_sync = 1'b0;
      repeat (p - p / 2) @(negedge clk);
    end
  endtask

  task automatic check_state(input string req, input int m, input int v, input int o);
    check(req, "mode", mode, m);
    check("R3", "osr", osr, exp_osr(2'(m)));
    check(req, "rate_valid", rate_valid, v);
    check(req, "out_of_range", out_of_range, o);
  endtask

  task automatic t_reset();
    check_state("R1", 0, 0, 0);
  endtask

  task automatic t_detect(input string req, input int p, input int m);
    run_frames(p, 4);
    check_state(req, m, 1, 0);
  endtask

  // R4: one odd frame, then one frame back in the old band
  task automatic t_hold();
    run_frames(T_DS + 6, 1);
    check("R4", "mode after one odd frame", mode, 2);
    run_frames(64, 1);
    check_state("R4", 2, 1, 0);
  endtask

  // R6: too fast, flag set, mode kept, then recovery
  task automatic t_oor();
    run_frames(40, 4);
    check_state("R6", 2, 0, 1);
    run_frames(64, 4);
    check_state("R6", 2, 1, 0);
  endtask

  task automatic t_force();
    auto_en = 1'b0;
    force_mode = 2'b01; @(negedge clk);
    check("R7", "forced mode 01", mode, 1);
    check("R7", "forced osr 01", osr, 64);
    force_mode = 2'b00; @(negedge clk);
    check("R7", "forced mode 00", mode, 0);
    check("R7", "forced osr 00", osr, 128);
    force_mode = 2'b11; @(negedge clk);
    check("R7", "forced mode 11", mode, 2);
    check("R7", "forced osr 11", osr, 32);
    auto_en = 1'b1; @(negedge clk);
    check("R7", "auto restored", mode, 2);
  endtask

  task automatic t_filter();
    filt_sel_sw = 1'b1; hw_strap = 1'b1; @(negedge clk);
    check("R8", "strap slow request", filt_slow, 0);
    hw_strap = 1'b0; @(negedge clk);
    check("R8", "software slow", filt_slow, 1);
    filt_sel_sw = 1'b0; @(negedge clk);
    check("R8", "software fast", filt_slow, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_detect("R2", 256, 0);
    t_detect("R2", 128, 1);
    t_detect("R2", 64, 2);
    t_hold();
    t_oor();
    t_detect("R9", T_SS, 0);
    t_detect("R9", T_SS - 1, 1);
    t_detect("R9", T_DS - 1, 2);
    t_detect("R9", T_QS, 2);
    run_frames(T_QS - 1, 4);
    check_state("R9", 2, 0, 1);
    run_frames(64, 4);
    check_state("R5", 2, 1, 0);
    t_force();
    t_filter();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule